// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block drives a raster display. It produces horizontal sync, vertical sync, a data-enable strobe and the current pixel column and row. Software sets the shape of the frame through a small register port. Each horizontal line and each vertical frame is split into four phases, in this order: sync, back porch, active, front porch. Software writes the length of each phase minus one. The block has a run/stop command bit, a polarity register for the three output strobes, and a vertical-sync interrupt. The interrupt has a sticky status bit and an enable mask.

Timing writes go into a pending copy of the timing registers. The generator moves them into its working copy only at a frame boundary, or at any time while it is stopped. A frame therefore never mixes old and new geometry. Reads return the pending values, so software can do a read-modify-write on any register.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal timing registers are at 4 (sync), 5 (back porch), 6 (active) and 7 (front porch). Each holds its length minus one, in pixel clocks. A line runs sync, back porch, active, front porch, and lasts the sum of (field+1).
- R2: The vertical timing registers are at 8 (sync), 9 (back porch), 10 (active) and 11 (front porch). Each holds its length minus one, in lines. A frame uses the same phase order and lasts the sum of (field+1) lines.
- R3: de is active only while both axes are in their active phase. pos_x is the pixel index within the active part of the line while de is active, and 0 otherwise. pos_y is the line index within the vertical active phase while running, and 0 otherwise.
- R4: Register 3 sets the output polarity. Bit 0 controls hsync, bit 1 vsync and bit 2 de. A set bit makes that output active-high and a clear bit makes it active-low. The reset value is 3'b111, and a change applies from the next cycle.
- R5: Writing 1 to bit 0 of register 0 starts the generator. In the cycle after the write edge, the generator is at line 0, pixel 0, with hsync and vsync both active.
- R6: Writing 0 to bit 0 of register 0 stops the generator. From the next cycle, every strobe sits at its inactive level and pos_x and pos_y are 0. The next start begins again from the frame origin.
- R7: A write to a timing register takes effect only at the start of the next frame, or at the next start if the generator is stopped. The frame in progress keeps its old geometry.
- R8: Bit 0 of register 2 is the vertical-sync status. It becomes 1 on the edge that ends the first cycle of each frame, which is the first cycle of vertical sync. It stays 1 until software writes 1 to that bit. Writing 0 to it has no effect, and a new event wins over a clear in the same cycle.
- R9: vsync_irq equals the status bit AND bit 0 of register 1. Register 1 is 8 bits wide and keeps all 8 written bits.
- R10: Reads return the current contents. Register 0 returns the run bit, register 1 the mask, register 2 the status, register 3 the polarity, and registers 4 to 11 the pending timing values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| hsync | output | 1 | Horizontal sync, polarity from register 3 bit 0 |
| vsync | output | 1 | Vertical sync, polarity from register 3 bit 1 |
| de | output | 1 | Data enable, polarity from register 3 bit 2 |
| pos_x | output | CNT_W | Column inside the active area |
| pos_y | output | CNT_W | Row inside the active area |
| vsync_irq | output | 1 | Masked vertical-sync interrupt |

## Verification
The first test is a fixed geometry with uneven phase lengths, so that a phase swap or an off-by-one in the minus-one coding shifts the strobes. Randomly drawn geometries, including one-cycle phases, then check the phase-wrap boundaries. Timing writes landing in mid-frame show whether the working copy is protected until the frame edge. Polarity flips and stop/restart sequences separate strobe inversion from gating. Status writes of 1 and of 0, mask values with bit 0 set and clear, and readbacks separate the sticky status from the masked interrupt line.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int ADDR_W = 4;
  localparam int NPH    = 4;
  localparam int HBASE  = 4;
  localparam int VBASE  = 8;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_POL  = 4'd3;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CNT_W-1:0]             wdata_i,
  input  logic                         load_i,
  input  logic                         stat_i,
  output logic                         run_o,
  output logic [7:0]                   mask_o,
  output logic [2:0]                   pol_o,
  output logic                         clr_o,
  output logic [NPH-1:0][CNT_W-1:0]    h_len_o,
  output logic [NPH-1:0][CNT_W-1:0]    v_len_o,
  output logic [CNT_W-1:0]             rdata_o
);
  logic                      run_q, run_d;
  logic [7:0]                mask_q, mask_d;
  logic [2:0]                pol_q, pol_d;
  logic [NPH-1:0][CNT_W-1:0] h_pend_q, h_pend_d, v_pend_q, v_pend_d;
  logic [NPH-1:0][CNT_W-1:0] h_act_q, h_act_d, v_act_q, v_act_d;

  always_comb begin
    run_d    = run_q;
    mask_d   = mask_q;
    pol_d    = pol_q;
    h_pend_d = h_pend_q;
    v_pend_d = v_pend_q;
    if (we_i) begin
      case (addr_i)
        A_CTRL:  run_d  = wdata_i[0];
        A_MASK:  mask_d = wdata_i[7:0];
        A_POL:   pol_d  = wdata_i[2:0];
        default: ;
      endcase
      for (int p = 0; p < NPH; p++) begin
        if (addr_i == ADDR_W'(HBASE + p)) h_pend_d[p] = wdata_i;
        if (addr_i == ADDR_W'(VBASE + p)) v_pend_d[p] = wdata_i;
      end
    end
  end

  always_comb begin
    h_act_d = h_act_q;
    v_act_d = v_act_q;
    if (load_i) begin
      h_act_d = h_pend_q;
      v_act_d = v_pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      mask_q   <= '0;
      pol_q    <= 3'b111;
      h_pend_q <= '0;
      v_pend_q <= '0;
      h_act_q  <= '0;
      v_act_q  <= '0;
    end else begin
      run_q    <= run_d;
      mask_q   <= mask_d;
      pol_q    <= pol_d;
      h_pend_q <= h_pend_d;
      v_pend_q <= v_pend_d;
      h_act_q  <= h_act_d;
      v_act_q  <= v_act_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[0]   = run_q;
      A_MASK:  rdata_o[7:0] = mask_q;
      A_STAT:  rdata_o[0]   = stat_i;
      A_POL:   rdata_o[2:0] = pol_q;
      default: begin
        for (int p = 0; p < NPH; p++) begin
          if (addr_i == ADDR_W'(HBASE + p)) rdata_o = h_pend_q[p];
          if (addr_i == ADDR_W'(VBASE + p)) rdata_o = v_pend_q[p];
        end
      end
    endcase
  end

  assign clr_o   = we_i && (addr_i == A_STAT) && wdata_i[0];
  assign run_o   = run_q;
  assign mask_o  = mask_q;
  assign pol_o   = pol_q;
  assign h_len_o = h_act_q;
  assign v_len_o = v_act_q;

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(h_act_q) && $stable(v_act_q)));
  // R9
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_MASK) |=> (mask_q == $past(wdata_i[7:0])));
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_i,
  input  logic                      step_i,
  input  logic [NPH-1:0][CNT_W-1:0] len_i,
  output phase_e                    phase_o,
  output logic [CNT_W-1:0]          cnt_o,
  output logic                      wrap_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last   = (cnt_q == len_i[phase_q]);
  assign wrap_o = run_i && step_i && last && (phase_q == PH_FRONT);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!run_i) begin
      phase_d = PH_SYNC;
      cnt_d   = '0;
    end else if (step_i) begin
      if (last) begin
        cnt_d   = '0;
        phase_d = phase_e'(phase_q + 2'd1);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && phase_q == PH_SYNC));
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= len_i[phase_q]));
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (set_i)      stat_d = 1'b1;
    else if (clr_i) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & en_i;

  // R8
  stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(set_i));
  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CNT_W-1:0]  pos_x,
  output logic [CNT_W-1:0]  pos_y,
  output logic              vsync_irq
);
  logic                      run, clr, stat, line_end, frame_end, load, vstart;
  logic [7:0]                mask;
  logic [2:0]                pol;
  logic [NPH-1:0][CNT_W-1:0] h_len, v_len;
  phase_e                    h_ph, v_ph;
  logic [CNT_W-1:0]          h_cnt, v_cnt;
  logic                      hs_raw, vs_raw, de_raw;

  assign load = !run || frame_end;

  dtg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .load_i(load), .stat_i(stat), .run_o(run),
    .mask_o(mask), .pol_o(pol), .clr_o(clr), .h_len_o(h_len),
    .v_len_o(v_len), .rdata_o(reg_rdata)
  );

  dtg_axis #(.CNT_W(CNT_W)) u_hax (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(1'b1), .len_i(h_len),
    .phase_o(h_ph), .cnt_o(h_cnt), .wrap_o(line_end)
  );

  dtg_axis #(.CNT_W(CNT_W)) u_vax (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(line_end), .len_i(v_len),
    .phase_o(v_ph), .cnt_o(v_cnt), .wrap_o(frame_end)
  );

  assign vstart = run && (h_ph == PH_SYNC) && (h_cnt == '0)
                      && (v_ph == PH_SYNC) && (v_cnt == '0);

  dtg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(vstart), .clr_i(clr), .en_i(mask[0]),
    .stat_o(stat), .irq_o(vsync_irq)
  );

  assign hs_raw = run && (h_ph == PH_SYNC);
  assign vs_raw = run && (v_ph == PH_SYNC);
  assign de_raw = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);

  assign hsync = pol[0] ? hs_raw : !hs_raw;
  assign vsync = pol[1] ? vs_raw : !vs_raw;
  assign de    = pol[2] ? de_raw : !de_raw;
  assign pos_x = de_raw ? h_cnt : '0;
  assign pos_y = (run && v_ph == PH_ACT) ? v_cnt : '0;

  // R6
  idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pos_x == '0 && pos_y == '0 && !de_raw));
  // R5
  start_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (hs_raw && vs_raw && vstart));
  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !(reg_we && reg_addr == A_CTRL && !reg_wdata[0])) |=> vstart);
endmodule

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
  localparam int CW = 12;

  logic          clk, rst_n, we;
  logic [3:0]    addr;
  logic [CW-1:0] wdata, rdata;
  logic          hsync, vsync, de, irq;
  logic [CW-1:0] px, py;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit chk_en = 0;

  int m_run, m_t, m_stat, m_mask, m_pol;
  int m_cfg[8];
  int m_pend[8];

  disp_timing_gen #(.CNT_W(CW)) i_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .hsync(hsync), .vsync(vsync), .de(de), .pos_x(px),
    .pos_y(py), .vsync_irq(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int line_len(input int c[8]);
    return c[0] + c[1] + c[2] + c[3] + 4;
  endfunction
  function automatic int frame_len(input int c[8]);
    return line_len(c) * (c[4] + c[5] + c[6] + c[7] + 4);
  endfunction

  // reference model of the registered state, updated on each edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_t = 0; m_stat = 0; m_mask = 0; m_pol = 7;
      foreach (m_cfg[i]) begin m_cfg[i] = 0; m_pend[i] = 0; end
    end else begin
      bit vs_evt;
      bit clr_evt;
      vs_evt  = (m_run != 0) && (m_t == 0);
      clr_evt = we && addr == 4'd2 && wdata[0];
      if (m_run != 0) begin
        if (m_t == frame_len(m_cfg) - 1) begin m_t = 0; m_cfg = m_pend; end
        else m_t++;
      end else begin
        m_t = 0; m_cfg = m_pend;
      end
      if (vs_evt) m_stat = 1;
      else if (clr_evt) m_stat = 0;
      if (we) begin
        case (addr)
          4'd0: m_run = int'(wdata[0]);
          4'd1: m_mask = int'(wdata[7:0]);
          4'd3: m_pol = int'(wdata[2:0]);
          default: if (addr >= 4 && addr <= 11) m_pend[addr-4] = int'(wdata);
        endcase
      end
    end
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      int hl, col, ln, hb0, vb0;
      bit hs, vs, hd, vd;
      int ex, ey;
      hl  = line_len(m_cfg);
      col = m_t % hl;
      ln  = m_t / hl;
      hb0 = m_cfg[0] + m_cfg[1] + 2;
      vb0 = m_cfg[4] + m_cfg[5] + 2;
      hs  = (m_run != 0) && col < m_cfg[0] + 1;
      vs  = (m_run != 0) && ln < m_cfg[4] + 1;
      hd  = (m_run != 0) && col >= hb0 && col < hb0 + m_cfg[2] + 1;
      vd  = (m_run != 0) && ln >= vb0 && ln < vb0 + m_cfg[6] + 1;
      ex  = (hd && vd) ? col - hb0 : 0;
      ey  = vd ? ln - vb0 : 0;
      chk("R1 hsync", int'(hsync), m_pol[0] ? int'(hs) : int'(!hs));
      chk("R2 vsync", int'(vsync), m_pol[1] ? int'(vs) : int'(!vs));
      chk("R3 de",    int'(de),    m_pol[2] ? int'(hd && vd) : int'(!(hd && vd)));
      chk("R3 pos_x", int'(px), ex);
      chk("R3 pos_y", int'(py), ey);
      chk("R9 irq",   int'(irq), m_stat & m_mask & 1);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1; addr = 4'(a); wdata = CW'(d);
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = int'(rdata);
  endtask

  task automatic load_cfg(input int c[8]);
    for (int i = 0; i < 8; i++) wr(4 + i, c[i]);
  endtask

  initial begin
    int ca[8] = '{1, 2, 7, 1, 0, 1, 4, 0};
    int cr[8];
    int v;
    void'($urandom(32'd20240611));
    rst_n = 0; we = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R4 reset hsync", int'(hsync), 0);
    chk("R6 reset de", int'(de), 0);
    chk("R8 reset irq", int'(irq), 0);
    rd(3, v); chk("R10 pol reset", v, 7);
    chk_en = 1;

    // directed geometry
    load_cfg(ca);
    rd(6, v); chk("R10 readback hact", v, 7);
    wr(1, 8'hA5);
    rd(1, v); chk("R10 mask readback", v, 8'hA5);
    wr(0, 1);
    chk("R5 start hsync", int'(hsync), 1);
    chk("R5 start vsync", int'(vsync), 1);
    repeat (frame_len(ca) * 2 + 7) @(negedge clk);
    chk("R8 status sticky", int'(irq), 1);
    wr(2, 0);
    rd(2, v); chk("R8 write zero no effect", v, 1);
    wr(2, 1);
    rd(2, v); chk("R8 w1c", v, m_stat);
    wr(1, 8'hA4);
    repeat (frame_len(ca)) @(negedge clk);
    chk("R9 masked irq", int'(irq), 0);
    rd(1, v); chk("R9 mask bits kept", v, 8'hA4);
    wr(1, 8'h01);

    // R7: mid-frame geometry change
    repeat (20) @(negedge clk);
    wr(6, 3); wr(10, 2);
    repeat (frame_len(ca) * 2) @(negedge clk);

    // R4: polarity flips
    wr(3, 0);
    repeat (60) @(negedge clk);
    wr(3, 5);
    repeat (60) @(negedge clk);

    // R6: stop and restart
    wr(0, 0);
    chk("R6 stopped hsync", int'(hsync), 0);
    chk("R6 stopped vsync", int'(vsync), 1);
    chk("R6 stopped pos", int'(px) + int'(py), 0);
    repeat (5) @(negedge clk);
    wr(0, 1);
    chk("R5 restart hsync", int'(hsync), 1);

    // random geometries with mixed writes
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 8; i++) cr[i] = $urandom_range(5, 0);
      load_cfg(cr);
      repeat ($urandom_range(300, 40)) @(negedge clk);
      if ($urandom_range(3, 0) == 0) wr(3, $urandom_range(7, 0));
      if ($urandom_range(3, 0) == 0) wr(2, 1);
      if ($urandom_range(4, 0) == 0) begin wr(0, 0); repeat (3) @(negedge clk); wr(0, 1); end
      repeat (frame_len(m_pend) * 2 + 10) @(negedge clk);
    end

    chk_en = 0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule